// File: doc/BRIEF.md
# Compare-and-Logic ALU with Truth Flag

This block is the 8-bit compute stage of a small processor core. It receives two operands and a 5-bit operation code, and it serves two instruction groups. Bitwise, shift and rotate operations form the first group. They return an 8-bit value at once, and the surrounding core writes that value back to the first operand's register. Unsigned comparisons and zero tests form the second group. They return no data. Instead they load a single registered truth flag, which the core uses to decide whether later conditional instructions execute.

The upper two bits of the operation code pick the group. The lower three bits pick the operation inside that group. The truth flag changes only on a rising clock edge, and only when the valid strobe is high and a comparison is selected. At every other time it keeps its value.

Top module: `cmplogic_alu`

## Requirements
- R1: When `opCode[4:3]` = 01 and `opValid` = 1, the flag takes the unsigned outcome of the selected test at the next rising edge. For `opCode[2:0]`, 000 is A>B, 001 is A>=B, 010 is A<B, 011 is A<=B, 100 is A==B, 101 is A!=B, 110 is A==0 and 111 is A!=0.
- R2: While `opCode[4:3]` = 01, `result` is 0.
- R3: While `opCode[4:3]` = 00, `result` is combinational. `opCode[2:0]` 000 gives A AND B, 001 gives A OR B, 010 gives A XOR B, and 011 gives NOT B (A is ignored).
- R4: For `opCode` 00100, `result` is A shifted left by `opB[2:0]`. For 00101, it is A shifted right by `opB[2:0]`. Both shifts fill with zeros, and `opB[7:3]` is ignored.
- R5: For `opCode` 00110, `result` is A rotated right by `opB[2:0]`. For 00111, it is A rotated left by `opB[2:0]`.
- R6: While `opValid` = 0, the truth flag keeps its value at every edge, whatever the operation code.
- R7: A valid operation in the bitwise group (`opCode[4:3]` = 00) leaves the truth flag unchanged.
- R8: When `opCode[4:3]` is 10 or 11, `result` is 0 and the truth flag is unchanged, even with `opValid` = 1.
- R9: A synchronous reset (`rst` = 1 at a rising edge) clears the truth flag to 0.
- R10: With A = 0x20 and B = 0x35, a greater-than test clears the flag and a less-than test sets it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Marks the current operation as issued |
| opCode | input | 5 | Group in [4:3], operation selector in [2:0] |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand; its low 3 bits set the shift or rotate amount |
| result | output | 8 | Combinational data result of the bitwise group |
| truthFlag | output | 1 | Registered comparison outcome |

## Verification
On every cycle, the assertions check the following:
- the result is zero outside the bitwise group;
- the flag holds whenever no comparison is loaded;
- the flag reads zero after reset;
- the decoder never enables both groups at once;
- the flag follows the fixed 0x20/0x35 case.

Only the bench's scenarios can show that each selector computes the right value. This covers every logic, shift and rotate code and every comparison code, including unsigned ordering across the sign bit, equal operands and shift amounts taken modulo eight.

// File: rtl/cmplogic_pkg.sv
package cmplogic_pkg;

  localparam int OP_W   = 5;
  localparam int SEL_W  = 3;
  localparam int GRP_W  = OP_W - SEL_W;

  localparam logic [GRP_W-1:0] GRP_LOGIC = 2'b00;
  localparam logic [GRP_W-1:0] GRP_CMP   = 2'b01;

  typedef enum logic [SEL_W-1:0] {
    CMP_GT  = 3'b000,
    CMP_GE  = 3'b001,
    CMP_LT  = 3'b010,
    CMP_LE  = 3'b011,
    CMP_EQ  = 3'b100,
    CMP_NE  = 3'b101,
    CMP_ZR  = 3'b110,
    CMP_NZ  = 3'b111
  } cmpSel_e;

  typedef enum logic [SEL_W-1:0] {
    LOG_AND = 3'b000,
    LOG_OR  = 3'b001,
    LOG_XOR = 3'b010,
    LOG_NOT = 3'b011,
    LOG_SHL = 3'b100,
    LOG_SHR = 3'b101,
    LOG_ROR = 3'b110,
    LOG_ROL = 3'b111
  } logicSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic             flagLoad;
    logic             logicEn;
    logic [SEL_W-1:0] sel;
  } aluStrobe_t;

endpackage

// File: rtl/cmplogic_ctrl.sv
module cmplogic_ctrl
  import cmplogic_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluStrobe_t      strobes
);

  logic [GRP_W-1:0] grp;

  assign grp = opCode[OP_W-1:SEL_W];

  always_comb begin
    strobes.sel      = opCode[SEL_W-1:0];
    strobes.logicEn  = (grp == GRP_LOGIC);
    strobes.flagLoad = opValid && (grp == GRP_CMP);
  end

  // Both groups must never be enabled together (R2, R7)
  always_comb begin
    assert_group_exclusive_R7: assert ($onehot0({strobes.flagLoad, strobes.logicEn}));
  end

endmodule

// File: rtl/cmplogic_dp.sv
module cmplogic_dp
  import cmplogic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  aluStrobe_t        strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              truthFlag
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [SHAMT_W-1:0]  shAmt;
  logic [2*DATA_W-1:0] dblA;
  logic [2*DATA_W-1:0] rorWide;
  logic [2*DATA_W-1:0] rolWide;
  logic                cmpOut;

  assign shAmt   = opB[SHAMT_W-1:0];
  assign dblA    = {opA, opA};
  assign rorWide = dblA >> shAmt;
  assign rolWide = dblA << shAmt;

  // Combinational data result of the bitwise group
  always_comb begin
    result = '0;
    if (strobes.logicEn) begin
      unique case (logicSel_e'(strobes.sel))
        LOG_AND: result = opA & opB;
        LOG_OR:  result = opA | opB;
        LOG_XOR: result = opA ^ opB;
        LOG_NOT: result = ~opB;
        LOG_SHL: result = opA << shAmt;
        LOG_SHR: result = opA >> shAmt;
        LOG_ROR: result = rorWide[DATA_W-1:0];
        LOG_ROL: result = rolWide[2*DATA_W-1:DATA_W];
        default: result = '0;
      endcase
    end
  end

  // Unsigned comparison outcome
  always_comb begin
    unique case (cmpSel_e'(strobes.sel))
      CMP_GT:  cmpOut = opA >  opB;
      CMP_GE:  cmpOut = opA >= opB;
      CMP_LT:  cmpOut = opA <  opB;
      CMP_LE:  cmpOut = opA <= opB;
      CMP_EQ:  cmpOut = opA == opB;
      CMP_NE:  cmpOut = opA != opB;
      CMP_ZR:  cmpOut = opA == '0;
      CMP_NZ:  cmpOut = opA != '0;
      default: cmpOut = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                   truthFlag <= 1'b0;
    else if (strobes.flagLoad) truthFlag <= cmpOut;
  end

  // Flag holds whenever no comparison is loaded (R6)
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobes.flagLoad |=> $stable(truthFlag));

  // Flag is clear on the first cycle after reset (R9)
  assert_flag_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (truthFlag == 1'b0));

endmodule

// File: rtl/cmplogic_alu.sv
module cmplogic_alu
  import cmplogic_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic              truthFlag
);

  aluStrobe_t strobes;

  cmplogic_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strobes (strobes)
  );

  cmplogic_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .truthFlag (truthFlag)
  );

  // Comparisons carry no data (R2)
  assert_cmp_no_data_R2: assert property (@(posedge clk) disable iff (rst)
    (opCode[OP_W-1:SEL_W] == GRP_CMP) |-> (result == '0));

  // Unused groups give zero and leave the flag alone (R8)
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (rst)
    opCode[OP_W-1] |-> (result == '0));
  assert_unused_hold_R8: assert property (@(posedge clk) disable iff (rst)
    opCode[OP_W-1] |=> $stable(truthFlag));

  // Bitwise group leaves the flag alone (R7)
  assert_logic_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode[OP_W-1:SEL_W] == GRP_LOGIC) |=> $stable(truthFlag));

  // Fixed operand case (R10)
  assert_gt_case_R10: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 5'b01000 && opA == 8'h20 && opB == 8'h35) |=> !truthFlag);
  assert_lt_case_R10: assert property (@(posedge clk) disable iff (rst)
    (opValid && opCode == 5'b01010 && opA == 8'h20 && opB == 8'h35) |=> truthFlag);

endmodule

// File: tb/sim_cmplogic_alu.sv
module sim_cmplogic_alu;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 19;

  // {opCode[4:0], opA, opB, expected}; for compares, expected[0] is the flag
  localparam logic [28:0] VEC [0:NVEC-1] = '{
    {5'b00000, 8'hF0, 8'h3C, 8'h30}, // R3 AND
    {5'b00001, 8'hF0, 8'h0C, 8'hFC}, // R3 OR
    {5'b00010, 8'hFF, 8'h0F, 8'hF0}, // R3 XOR
    {5'b00011, 8'h12, 8'h0F, 8'hF0}, // R3 NOT B
    {5'b00100, 8'h81, 8'h03, 8'h08}, // R4 SHL 3
    {5'b00100, 8'h81, 8'hF9, 8'h02}, // R4 SHL, upper bits ignored
    {5'b00101, 8'h81, 8'h04, 8'h08}, // R4 SHR 4
    {5'b00110, 8'h81, 8'h01, 8'hC0}, // R5 ROR 1
    {5'b00111, 8'h81, 8'h03, 8'h0C}, // R5 ROL 3
    {5'b00110, 8'h96, 8'h00, 8'h96}, // R5 ROR 0
    {5'b01000, 8'h20, 8'h35, 8'h00}, // R10 GT clears
    {5'b01010, 8'h20, 8'h35, 8'h01}, // R10 LT sets
    {5'b01000, 8'h80, 8'h7F, 8'h01}, // R1 GT unsigned
    {5'b01001, 8'h35, 8'h35, 8'h01}, // R1 GE equal
    {5'b01011, 8'h36, 8'h35, 8'h00}, // R1 LE false
    {5'b01100, 8'h35, 8'h35, 8'h01}, // R1 EQ
    {5'b01101, 8'h35, 8'h35, 8'h00}, // R1 NE
    {5'b01110, 8'h00, 8'h55, 8'h01}, // R1 zero test
    {5'b01111, 8'h00, 8'h55, 8'h00}  // R1 non-zero test
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [7:0] result;
  logic       truthFlag;

  int checkCount = 0;
  int failCount  = 0;
  int cycles     = 0;

  cmplogic_alu u0 (
    .clk       (clk),
    .rst       (rst),
    .opValid   (opValid),
    .opCode    (opCode),
    .opA       (opA),
    .opB       (opB),
    .result    (result),
    .truthFlag (truthFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9 reset flag", {7'b0, truthFlag}, 8'h00);
    rst = 1'b0;

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {opCode, opA, opB} = VEC[i][28:8];
      opValid = 1'b1;
      #1;
      if (opCode[3]) check($sformatf("R2 cmp result vec %0d", i), result, 8'h00);
      else           check($sformatf("R3/R4/R5 logic vec %0d", i), result, VEC[i][7:0]);
      @(negedge clk);
      opValid = 1'b0;
      if (opCode[3]) check($sformatf("R1/R10 flag vec %0d", i), {7'b0, truthFlag}, VEC[i][7:0]);
    end

    // Set flag to 1, then R6: compare that would clear it but valid low
    @(negedge clk);
    opCode = 5'b01100; opA = 8'h11; opB = 8'h11; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0; opCode = 5'b01101;
    check("R1 EQ sets flag", {7'b0, truthFlag}, 8'h01);
    repeat (2) @(negedge clk);
    check("R6 hold without valid", {7'b0, truthFlag}, 8'h01);

    // R7: valid bitwise op leaves flag
    opCode = 5'b00000; opA = 8'h00; opB = 8'h00; opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check("R7 logic op keeps flag", {7'b0, truthFlag}, 8'h01);

    // R8: unused groups
    opCode = 5'b10001; opA = 8'hFF; opB = 8'hFF; opValid = 1'b1;
    #1;
    check("R8 result zero 10", result, 8'h00);
    @(negedge clk);
    opCode = 5'b11101;
    #1;
    check("R8 result zero 11", result, 8'h00);
    @(negedge clk);
    opValid = 1'b0;
    check("R8 flag unchanged", {7'b0, truthFlag}, 8'h01);

    // R9: reset mid-run clears flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset clears", {7'b0, truthFlag}, 8'h00);

    finishRun();
  end

endmodule